// File: doc/BRIEF.md
# Linked-List Sharer Chain Manager

This block keeps track of which nodes hold a copy of each memory block when the list of copies is spread across the caches instead of being held in one place. The home side keeps a single head pointer per block. Each node's tag for that block holds a forward pointer and a backward pointer to the neighbouring holders, together with a membership flag. All these fields live in one module. A request/response interface drives the module, and it stands in for the network messages a real system would exchange.

A reader that does not yet hold the block is spliced in at the front of its chain. A node that drops its copy is unlinked by joining its two neighbours to each other. A writer walks the chain from the head, one node per cycle, and emits one invalidation per visited holder. When the walk ends, the writer is the sole holder. During a walk the manager accepts no other request, so a request held at the input waits until the walk is over. A probe operation reads back the head and a node's links without changing anything.

The pointer code equal to NODES is the null pointer. It ends a chain and marks an empty head. Operation codes on `req_op` and `rsp_op` are 0 = read, 1 = write, 2 = evict, 3 = probe.

Top module: `sharechain_mgr`

## Requirements
- R1: After reset every block's head is the null code (NODES), no node is a member of any chain, `req_ready` is 1, and `rsp_valid` and `inv_valid` are 0.
- R2: A read (op 0) by a non-member is answered one cycle after acceptance. The requester becomes the head, with forward pointer equal to the old head (null if the chain was empty), backward pointer null and member 1. The old head's backward pointer becomes the requester.
- R3: A read by a node already in the chain changes nothing. The response reports the current head and that node's current links with member 1.
- R4: An evict (op 2) of a member in the middle of a chain links its predecessor's forward pointer to its successor and its successor's backward pointer to its predecessor. The response, one cycle after acceptance, reports member 0 and null links.
- R5: An evict of the head member makes the home head equal to its successor, or null if it was the only member, and that successor's backward pointer becomes null.
- R6: An evict by a non-member leaves the chain unchanged. The response reports the current head, null links and member 0.
- R7: A write (op 1) accepted on edge k to a chain of m members visits them from head to tail. After edge k+j the j-th member is reported on `inv_node` with `inv_valid` 1, except that the writer's own position gives `inv_valid` 0.
- R8: A write completes with a response after edge k+m+1 (after edge k+1 for an empty chain). The writer is then the only member, with null links, and the head points to it.
- R9: From the edge that accepts a write until its response, `req_ready` is 0. A request held at the input is accepted only afterwards and sees the chain as the write left it.
- R10: A probe (op 3) changes nothing. One cycle after acceptance it reports the block's head and the node's forward pointer, backward pointer and member flag.
- R11: Operations on one block leave every other block's head and links unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 2 | 0 read, 1 write, 2 evict, 3 probe |
| req_node | input | log2(NODES) | Requesting node |
| req_blk | input | log2(BLOCKS) | Memory block addressed |
| req_ready | output | 1 | Request accepted on this edge when valid |
| rsp_valid | output | 1 | Response present for one cycle |
| rsp_op | output | 2 | Operation being answered |
| rsp_node | output | log2(NODES) | Node of the answered request |
| rsp_blk | output | log2(BLOCKS) | Block of the answered request |
| rsp_head | output | log2(NODES+1) | Block head after the operation |
| rsp_fwd | output | log2(NODES+1) | Node's forward pointer after the operation |
| rsp_bwd | output | log2(NODES+1) | Node's backward pointer after the operation |
| rsp_member | output | 1 | Node holds a copy after the operation |
| inv_valid | output | 1 | Invalidation issued this cycle |
| inv_node | output | log2(NODES) | Node being invalidated |
| inv_blk | output | log2(BLOCKS) | Block being invalidated |

## Verification
Reads, evicts and probes answer in the cycle that follows their accepting edge. A write over m members shows its j-th invalidation after j further edges and its response after m+1. A behavioural model holds one queue of node numbers per block and predicts, for every cycle of every operation, the values of `req_ready`, `rsp_valid`, `inv_valid` and the payload. The bench drives inputs and samples outputs on the falling edge, so each comparison falls in the exact cycle where the result is due. The stall case keeps a second request on the input throughout a walk and checks that `req_ready` stays low until the write's response.

// File: rtl/sharechain_pkg.sv
package sharechain_pkg;

  typedef enum logic [1:0] {
    OP_READ  = 2'd0,
    OP_WRITE = 2'd1,
    OP_EVICT = 2'd2,
    OP_PROBE = 2'd3
  } sc_op_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_WALK = 2'd1,
    ST_FIN  = 2'd2
  } sc_state_e;

endpackage

// File: rtl/sharechain_head_tbl.sv
// Home-side table: one chain head pointer per memory block.
module sharechain_head_tbl #(
  parameter int BLOCKS = 16,
  parameter int PW     = 4,
  parameter int NULLV  = 8,
  localparam int BW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [BW-1:0] rd_blk,
  output logic [PW-1:0] rd_ptr,
  input  logic          wr_en,
  input  logic [BW-1:0] wr_blk,
  input  logic [PW-1:0] wr_ptr
);

  localparam logic [PW-1:0] NULLP = PW'(NULLV);

  logic [PW-1:0] head_mem [BLOCKS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < BLOCKS; i++) head_mem[i] <= NULLP;
    end else if (wr_en) begin
      head_mem[wr_blk] <= wr_ptr;
    end
  end

  assign rd_ptr = head_mem[rd_blk];

  // R1
  head_code_range_chk: assert property (@(posedge clk) disable iff (rst)
    wr_en |-> (wr_ptr <= NULLP));

endmodule

// File: rtl/sharechain_link_ram.sv
// Per-node tag link fields, indexed by {block, node}.
// Port A writes a whole entry, port B only a forward pointer, port C only a
// backward pointer.
module sharechain_link_ram #(
  parameter int NODES  = 8,
  parameter int BLOCKS = 16,
  parameter int PW     = 4,
  localparam int NW    = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
  localparam int AW    = NW + BW,
  localparam int DEPTH = 2 ** AW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [AW-1:0] rd_idx,
  output logic [PW-1:0] rd_fwd,
  output logic [PW-1:0] rd_bwd,
  output logic          rd_mem,
  input  logic          a_en,
  input  logic [AW-1:0] a_idx,
  input  logic [PW-1:0] a_fwd,
  input  logic [PW-1:0] a_bwd,
  input  logic          a_mem,
  input  logic          b_en,
  input  logic [AW-1:0] b_idx,
  input  logic [PW-1:0] b_fwd,
  input  logic          c_en,
  input  logic [AW-1:0] c_idx,
  input  logic [PW-1:0] c_bwd
);

  localparam logic [PW-1:0] NULLP = PW'(NODES);

  logic [PW-1:0] fwd_mem [DEPTH];
  logic [PW-1:0] bwd_mem [DEPTH];
  logic          mbr_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < DEPTH; i++) begin
        fwd_mem[i] <= NULLP;
        bwd_mem[i] <= NULLP;
        mbr_mem[i] <= 1'b0;
      end
    end else begin
      if (a_en) begin
        fwd_mem[a_idx] <= a_fwd;
        bwd_mem[a_idx] <= a_bwd;
        mbr_mem[a_idx] <= a_mem;
      end
      if (b_en) fwd_mem[b_idx] <= b_fwd;
      if (c_en) bwd_mem[c_idx] <= c_bwd;
    end
  end

  assign rd_fwd = fwd_mem[rd_idx];
  assign rd_bwd = bwd_mem[rd_idx];
  assign rd_mem = mbr_mem[rd_idx];

  // R4
  splice_ports_distinct_ab_chk: assert property (@(posedge clk) disable iff (rst)
    (a_en && b_en) |-> (a_idx != b_idx));

  // R4
  splice_ports_distinct_ac_chk: assert property (@(posedge clk) disable iff (rst)
    (a_en && c_en) |-> (a_idx != c_idx));

endmodule

// File: rtl/sharechain_ctrl.sv
// Sequencer: splices readers in, unlinks evictions, walks chains on writes.
module sharechain_ctrl
  import sharechain_pkg::*;
#(
  parameter int NODES  = 8,
  parameter int BLOCKS = 16,
  localparam int NW    = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
  localparam int PW    = $clog2(NODES + 1),
  localparam int AW    = NW + BW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [NW-1:0] req_node,
  input  logic [BW-1:0] req_blk,
  output logic          req_ready,
  output logic [BW-1:0] hd_rd_blk,
  input  logic [PW-1:0] hd_rd_ptr,
  output logic          hd_wr_en,
  output logic [BW-1:0] hd_wr_blk,
  output logic [PW-1:0] hd_wr_ptr,
  output logic [AW-1:0] lk_rd_idx,
  input  logic [PW-1:0] lk_rd_fwd,
  input  logic [PW-1:0] lk_rd_bwd,
  input  logic          lk_rd_mem,
  output logic          a_en,
  output logic [AW-1:0] a_idx,
  output logic [PW-1:0] a_fwd,
  output logic [PW-1:0] a_bwd,
  output logic          a_mem,
  output logic          b_en,
  output logic [AW-1:0] b_idx,
  output logic [PW-1:0] b_fwd,
  output logic          c_en,
  output logic [AW-1:0] c_idx,
  output logic [PW-1:0] c_bwd,
  output logic          rsp_valid,
  output logic [1:0]    rsp_op,
  output logic [NW-1:0] rsp_node,
  output logic [BW-1:0] rsp_blk,
  output logic [PW-1:0] rsp_head,
  output logic [PW-1:0] rsp_fwd,
  output logic [PW-1:0] rsp_bwd,
  output logic          rsp_member,
  output logic          inv_valid,
  output logic [NW-1:0] inv_node,
  output logic [BW-1:0] inv_blk
);

  localparam logic [PW-1:0] NULLP = PW'(NODES);

  sc_state_e     st_q;
  logic [NW-1:0] node_q;
  logic [BW-1:0] blk_q;
  logic [PW-1:0] cur_q;
  logic          accept;
  sc_op_e        op_in;
  logic [PW-1:0] req_ptr, wr_ptr_q;
  logic [PW-1:0] nx_head, nx_fwd, nx_bwd;
  logic          nx_mem;

  function automatic logic [AW-1:0] mk_idx(logic [BW-1:0] b, logic [NW-1:0] n);
    return {b, n};
  endfunction

  assign req_ready = (st_q == ST_IDLE);
  assign accept    = req_valid && req_ready;
  assign op_in     = sc_op_e'(req_op);
  assign req_ptr   = PW'(req_node);
  assign wr_ptr_q  = PW'(node_q);
  assign hd_rd_blk = req_blk;
  assign lk_rd_idx = (st_q == ST_WALK) ? mk_idx(blk_q, cur_q[NW-1:0])
                                       : mk_idx(req_blk, req_node);

  // Table updates for the current cycle.
  always_comb begin
    hd_wr_en  = 1'b0; hd_wr_blk = req_blk; hd_wr_ptr = NULLP;
    a_en = 1'b0; a_idx = mk_idx(req_blk, req_node);
    a_fwd = NULLP; a_bwd = NULLP; a_mem = 1'b0;
    b_en = 1'b0; b_idx = mk_idx(req_blk, lk_rd_bwd[NW-1:0]); b_fwd = lk_rd_fwd;
    c_en = 1'b0; c_idx = mk_idx(req_blk, lk_rd_fwd[NW-1:0]); c_bwd = lk_rd_bwd;
    case (st_q)
      ST_IDLE: begin
        if (accept && op_in == OP_READ && !lk_rd_mem) begin
          a_en = 1'b1; a_fwd = hd_rd_ptr; a_mem = 1'b1;
          if (hd_rd_ptr != NULLP) begin
            c_en = 1'b1; c_idx = mk_idx(req_blk, hd_rd_ptr[NW-1:0]); c_bwd = req_ptr;
          end
          hd_wr_en = 1'b1; hd_wr_ptr = req_ptr;
        end else if (accept && op_in == OP_EVICT && lk_rd_mem) begin
          a_en = 1'b1;
          if (lk_rd_bwd != NULLP) b_en = 1'b1;
          else begin hd_wr_en = 1'b1; hd_wr_ptr = lk_rd_fwd; end
          if (lk_rd_fwd != NULLP) c_en = 1'b1;
        end
      end
      ST_WALK: begin
        a_idx = mk_idx(blk_q, cur_q[NW-1:0]);
        a_en  = (cur_q != wr_ptr_q);
      end
      ST_FIN: begin
        a_en = 1'b1; a_idx = mk_idx(blk_q, node_q); a_mem = 1'b1;
        hd_wr_en = 1'b1; hd_wr_blk = blk_q; hd_wr_ptr = wr_ptr_q;
      end
      default: ;
    endcase
  end

  // Response contents for single-cycle operations.
  always_comb begin
    nx_head = hd_rd_ptr; nx_fwd = lk_rd_fwd; nx_bwd = lk_rd_bwd; nx_mem = lk_rd_mem;
    case (op_in)
      OP_READ: if (!lk_rd_mem) begin
        nx_head = req_ptr; nx_fwd = hd_rd_ptr; nx_bwd = NULLP; nx_mem = 1'b1;
      end
      OP_EVICT: begin
        if (lk_rd_mem && lk_rd_bwd == NULLP) nx_head = lk_rd_fwd;
        nx_fwd = NULLP; nx_bwd = NULLP; nx_mem = 1'b0;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st_q <= ST_IDLE; node_q <= '0; blk_q <= '0; cur_q <= NULLP;
      rsp_valid <= 1'b0; rsp_op <= 2'd0; rsp_node <= '0; rsp_blk <= '0;
      rsp_head <= NULLP; rsp_fwd <= NULLP; rsp_bwd <= NULLP; rsp_member <= 1'b0;
      inv_valid <= 1'b0; inv_node <= '0; inv_blk <= '0;
    end else begin
      rsp_valid <= 1'b0;
      inv_valid <= 1'b0;
      case (st_q)
        ST_IDLE: if (accept) begin
          node_q <= req_node; blk_q <= req_blk;
          if (op_in == OP_WRITE) begin
            cur_q <= hd_rd_ptr;
            st_q  <= (hd_rd_ptr == NULLP) ? ST_FIN : ST_WALK;
          end else begin
            rsp_valid <= 1'b1; rsp_op <= req_op; rsp_node <= req_node; rsp_blk <= req_blk;
            rsp_head <= nx_head; rsp_fwd <= nx_fwd; rsp_bwd <= nx_bwd; rsp_member <= nx_mem;
          end
        end
        ST_WALK: begin
          if (cur_q != wr_ptr_q) begin
            inv_valid <= 1'b1; inv_node <= cur_q[NW-1:0]; inv_blk <= blk_q;
          end
          cur_q <= lk_rd_fwd;
          if (lk_rd_fwd == NULLP) st_q <= ST_FIN;
        end
        ST_FIN: begin
          rsp_valid <= 1'b1; rsp_op <= OP_WRITE; rsp_node <= node_q; rsp_blk <= blk_q;
          rsp_head <= wr_ptr_q; rsp_fwd <= NULLP; rsp_bwd <= NULLP; rsp_member <= 1'b1;
          st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  // R9
  write_stalls_input_chk: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && req_op == OP_WRITE) |=> !req_ready);

  // R7
  writer_not_invalidated_chk: assert property (@(posedge clk) disable iff (rst)
    inv_valid |-> (inv_node != node_q && !rsp_valid));

  // R8
  writer_sole_owner_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_op == OP_WRITE) |->
      (rsp_member && rsp_head == PW'(rsp_node) && rsp_fwd == NULLP && rsp_bwd == NULLP));

  // R2
  reader_is_member_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_op == OP_READ) |-> (rsp_member && rsp_head != NULLP));

  // R4
  evicted_unlinked_chk: assert property (@(posedge clk) disable iff (rst)
    (rsp_valid && rsp_op == OP_EVICT) |->
      (!rsp_member && rsp_fwd == NULLP && rsp_bwd == NULLP));

endmodule

// File: rtl/sharechain_mgr.sv
module sharechain_mgr #(
  parameter int NODES  = 8,
  parameter int BLOCKS = 16,
  localparam int NW    = (NODES > 1) ? $clog2(NODES) : 1,
  localparam int BW    = (BLOCKS > 1) ? $clog2(BLOCKS) : 1,
  localparam int PW    = $clog2(NODES + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [1:0]    req_op,
  input  logic [NW-1:0] req_node,
  input  logic [BW-1:0] req_blk,
  output logic          req_ready,
  output logic          rsp_valid,
  output logic [1:0]    rsp_op,
  output logic [NW-1:0] rsp_node,
  output logic [BW-1:0] rsp_blk,
  output logic [PW-1:0] rsp_head,
  output logic [PW-1:0] rsp_fwd,
  output logic [PW-1:0] rsp_bwd,
  output logic          rsp_member,
  output logic          inv_valid,
  output logic [NW-1:0] inv_node,
  output logic [BW-1:0] inv_blk
);

  localparam int AW = NW + BW;

  logic [BW-1:0] hd_rd_blk, hd_wr_blk;
  logic [PW-1:0] hd_rd_ptr, hd_wr_ptr;
  logic          hd_wr_en;
  logic [AW-1:0] lk_rd_idx, a_idx, b_idx, c_idx;
  logic [PW-1:0] lk_rd_fwd, lk_rd_bwd, a_fwd, a_bwd, b_fwd, c_bwd;
  logic          lk_rd_mem, a_en, a_mem, b_en, c_en;

  sharechain_ctrl #(.NODES(NODES), .BLOCKS(BLOCKS)) ctrl_i (
    .clk(clk), .rst(rst),
    .req_valid(req_valid), .req_op(req_op), .req_node(req_node), .req_blk(req_blk),
    .req_ready(req_ready),
    .hd_rd_blk(hd_rd_blk), .hd_rd_ptr(hd_rd_ptr),
    .hd_wr_en(hd_wr_en), .hd_wr_blk(hd_wr_blk), .hd_wr_ptr(hd_wr_ptr),
    .lk_rd_idx(lk_rd_idx), .lk_rd_fwd(lk_rd_fwd), .lk_rd_bwd(lk_rd_bwd), .lk_rd_mem(lk_rd_mem),
    .a_en(a_en), .a_idx(a_idx), .a_fwd(a_fwd), .a_bwd(a_bwd), .a_mem(a_mem),
    .b_en(b_en), .b_idx(b_idx), .b_fwd(b_fwd),
    .c_en(c_en), .c_idx(c_idx), .c_bwd(c_bwd),
    .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_node(rsp_node), .rsp_blk(rsp_blk),
    .rsp_head(rsp_head), .rsp_fwd(rsp_fwd), .rsp_bwd(rsp_bwd), .rsp_member(rsp_member),
    .inv_valid(inv_valid), .inv_node(inv_node), .inv_blk(inv_blk)
  );

  sharechain_head_tbl #(.BLOCKS(BLOCKS), .PW(PW), .NULLV(NODES)) head_i (
    .clk(clk), .rst(rst),
    .rd_blk(hd_rd_blk), .rd_ptr(hd_rd_ptr),
    .wr_en(hd_wr_en), .wr_blk(hd_wr_blk), .wr_ptr(hd_wr_ptr)
  );

  sharechain_link_ram #(.NODES(NODES), .BLOCKS(BLOCKS), .PW(PW)) link_i (
    .clk(clk), .rst(rst),
    .rd_idx(lk_rd_idx), .rd_fwd(lk_rd_fwd), .rd_bwd(lk_rd_bwd), .rd_mem(lk_rd_mem),
    .a_en(a_en), .a_idx(a_idx), .a_fwd(a_fwd), .a_bwd(a_bwd), .a_mem(a_mem),
    .b_en(b_en), .b_idx(b_idx), .b_fwd(b_fwd),
    .c_en(c_en), .c_idx(c_idx), .c_bwd(c_bwd)
  );

endmodule

// File: tb/sharechain_mgr_tb.sv
module sharechain_mgr_tb_top;

  localparam int NODES = 8;
  localparam int BLOCKS = 4;
  localparam int NULLC = NODES;
  localparam int RD = 0, WR = 1, EV = 2, PR = 3;

  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       req_valid = 1'b0;
  logic [1:0] req_op = 2'd0;
  logic [2:0] req_node = '0;
  logic [1:0] req_blk = '0;
  logic       req_ready, rsp_valid, rsp_member, inv_valid;
  logic [1:0] rsp_op, rsp_blk, inv_blk;
  logic [2:0] rsp_node, inv_node;
  logic [3:0] rsp_head, rsp_fwd, rsp_bwd;

  int n_chk = 0;
  int n_fail = 0;
  int chain [BLOCKS][$];

  always #5 clk = ~clk;

  sharechain_mgr #(.NODES(NODES), .BLOCKS(BLOCKS)) dut_i (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_node(req_node), .req_blk(req_blk), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_op(rsp_op), .rsp_node(rsp_node), .rsp_blk(rsp_blk),
    .rsp_head(rsp_head), .rsp_fwd(rsp_fwd), .rsp_bwd(rsp_bwd), .rsp_member(rsp_member),
    .inv_valid(inv_valid), .inv_node(inv_node), .inv_blk(inv_blk)
  );

  task automatic chk(string rq, string what, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", rq, what, act, exp);
    end
  endtask

  function automatic int find(int b, int n);
    foreach (chain[b][i]) if (chain[b][i] == n) return i;
    return -1;
  endfunction

  task automatic drive(int op, int n, int b);
    req_valid = 1'b1; req_op = 2'(op); req_node = 3'(n); req_blk = 2'(b);
  endtask

  // Called at a falling edge with the request on the inputs.
  task automatic complete(int op, int n, int b, string rq,
                          bit keep, int nop, int nn, int nb);
    int pos, sz, e_head, e_fwd, e_bwd, e_mem;
    int walk [$];
    @(posedge clk);
    @(negedge clk);
    if (keep) drive(nop, nn, nb); else req_valid = 1'b0;
    pos = find(b, n);
    sz  = chain[b].size();
    if (op == WR) begin
      walk = chain[b];
      chain[b] = {n};
      chk(rq, "ready low after write accept", int'(req_ready), 0);
      chk(rq, "no response during walk", int'(rsp_valid), 0);
      foreach (walk[j]) begin
        @(posedge clk);
        @(negedge clk);
        chk(rq, "inv_valid per visited member", int'(inv_valid), int'(walk[j] != n));
        if (walk[j] != n) begin
          chk(rq, "inv_node order", int'(inv_node), walk[j]);
          chk(rq, "inv_blk", int'(inv_blk), b);
        end
        chk(rq, "ready low in walk", int'(req_ready), 0);
        chk(rq, "rsp low in walk", int'(rsp_valid), 0);
      end
      @(posedge clk);
      @(negedge clk);
      chk(rq, "write rsp_valid at k+m+1", int'(rsp_valid), 1);
      chk(rq, "write rsp_op", int'(rsp_op), WR);
      chk(rq, "write head is writer", int'(rsp_head), n);
      chk(rq, "write fwd null", int'(rsp_fwd), NULLC);
      chk(rq, "write bwd null", int'(rsp_bwd), NULLC);
      chk(rq, "write member", int'(rsp_member), 1);
      chk(rq, "no inv with write rsp", int'(inv_valid), 0);
      chk(rq, "ready back after write", int'(req_ready), 1);
      return;
    end
    e_fwd = NULLC; e_bwd = NULLC; e_mem = 0;
    if (op == RD && pos < 0) begin
      e_fwd = (sz > 0) ? chain[b][0] : NULLC;
      chain[b].push_front(n);
      e_mem = 1;
    end else if (op == EV) begin
      if (pos >= 0) chain[b].delete(pos);
    end else if (pos >= 0) begin
      e_fwd = (pos + 1 < sz) ? chain[b][pos+1] : NULLC;
      e_bwd = (pos > 0) ? chain[b][pos-1] : NULLC;
      e_mem = 1;
    end
    e_head = (chain[b].size() > 0) ? chain[b][0] : NULLC;
    chk(rq, "rsp_valid one cycle after accept", int'(rsp_valid), 1);
    chk(rq, "rsp_op", int'(rsp_op), op);
    chk(rq, "rsp_node", int'(rsp_node), n);
    chk(rq, "rsp_blk", int'(rsp_blk), b);
    chk(rq, "rsp_head", int'(rsp_head), e_head);
    chk(rq, "rsp_fwd", int'(rsp_fwd), e_fwd);
    chk(rq, "rsp_bwd", int'(rsp_bwd), e_bwd);
    chk(rq, "rsp_member", int'(rsp_member), e_mem);
    chk(rq, "no inv", int'(inv_valid), 0);
    chk(rq, "ready", int'(req_ready), 1);
  endtask

  task automatic run(int op, int n, int b, string rq);
    drive(op, n, b);
    complete(op, n, b, rq, 1'b0, 0, 0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1", "ready after reset", int'(req_ready), 1);
    chk("R1", "rsp_valid after reset", int'(rsp_valid), 0);
    chk("R1", "inv_valid after reset", int'(inv_valid), 0);
    for (int b = 0; b < BLOCKS; b++) run(PR, 0, b, "R1");
    // R2 head insertion
    run(RD, 3, 0, "R2");
    run(RD, 5, 0, "R2");
    run(RD, 1, 0, "R2");
    run(PR, 5, 0, "R10");
    run(PR, 3, 0, "R10");
    // R3 read by member
    run(RD, 5, 0, "R3");
    run(PR, 1, 0, "R3");
    // R11 other block
    run(RD, 2, 1, "R11");
    run(PR, 5, 1, "R11");
    // R4 middle evict
    run(EV, 5, 0, "R4");
    run(PR, 1, 0, "R4");
    run(PR, 3, 0, "R4");
    // R5 head evict
    run(EV, 1, 0, "R5");
    run(PR, 3, 0, "R5");
    // R6 non-member evict
    run(EV, 6, 0, "R6");
    run(PR, 3, 0, "R6");
    run(EV, 3, 0, "R5");
    run(PR, 3, 0, "R5");
    // R7 / R8 write by non-member
    run(RD, 3, 0, "R2");
    run(RD, 4, 0, "R2");
    run(RD, 6, 0, "R2");
    run(WR, 7, 0, "R7");
    run(PR, 6, 0, "R8");
    run(PR, 7, 0, "R8");
    // R7 write by a member in the middle
    run(RD, 0, 0, "R2");
    run(RD, 2, 0, "R2");
    run(WR, 0, 0, "R7");
    run(PR, 7, 0, "R8");
    // R8 write to empty chain
    run(WR, 1, 2, "R8");
    run(PR, 1, 2, "R8");
    // R9 request held during walk
    run(RD, 1, 3, "R9");
    run(RD, 2, 3, "R9");
    run(RD, 3, 3, "R9");
    drive(WR, 4, 3);
    complete(WR, 4, 3, "R9", 1'b1, RD, 5, 3);
    complete(RD, 5, 3, "R9", 1'b0, 0, 0, 0);
    run(PR, 4, 3, "R9");
    run(PR, 2, 3, "R9");
    // R11 untouched block
    run(PR, 2, 1, "R11");
    run(EV, 4, 3, "R4");
    run(PR, 5, 3, "R5");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++;
    n_fail++;
    $display("FAIL watchdog: actual still running expected finished");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule